// File: doc/BRIEF.md
# Demand-Based Performance-State Governor

This block picks one operating point (a frequency and voltage pair) shared by every core, since all cores draw their clock from a single source. It counts, per core, how many cycles the core reports itself busy over a fixed counting window. When the window closes, it takes the busiest core as the measure of demand and compares that core's utilisation against a high and a low percentage threshold. It then moves the selection at most one step toward faster or slower, or leaves it where it is. At the fastest regular point it may also step into a turbo point, subject to a software enable and a cap on how many cores are active.

A change is applied through a request/acknowledge interface to the clock and voltage control logic. The change takes two acknowledged steps, and the order of the steps depends on the direction of the move. Voltage rises before frequency, and frequency falls before voltage, so the supply always covers the clock. The pairs for the regular points come from a small table held on an input bus. The turbo pair has its own inputs. No new window is counted until the control side has acknowledged both steps.

Top module: `pstate_governor`

## Requirements
- R1: During and right after reset the selection is the slowest regular point, index NUM_PSTATES-1, with turbo off. The output pair is that table entry and `ctl_req` is low.
- R2: Each window lasts WIN_CYCLES counting cycles. If the busiest core's busy count times 100 is strictly greater than `thr_hi` times WIN_CYCLES, the index drops by one (index 0 is the fastest regular point). Equality holds the selection. At index 0 without turbo granted, the selection holds.
- R3: If the busiest core's busy count times 100 is strictly less than `thr_lo` times WIN_CYCLES, the index rises by one, up to NUM_PSTATES-1. Equality holds the selection. When both comparisons are true, the raise wins.
- R4: Table entry i sits at `pair_tbl[i*(F_W+V_W) +: F_W+V_W]`, with the frequency in the upper F_W bits and the voltage in the lower V_W bits. While turbo is selected, `turbo_freq` and `turbo_volt` are used instead.
- R5: On a move toward higher performance, the first step shows the new voltage with the old frequency. The second step shows both new values.
- R6: On a move toward lower performance, the first step shows the new frequency with the old voltage. The second step shows both new values.
- R7: `ctl_req` stays high and the output pair stays unchanged until a one-cycle `ctl_ack` pulse. The ack of the first step keeps `ctl_req` high. The ack of the second step drops it in the next cycle.
- R8: No busy cycles are counted and no evaluation happens while a change is outstanding. A new window starts in the cycle after the second ack, so each completed window causes at most one change.
- R9: Turbo is entered only when all of these hold: the selection is index 0 without turbo, `turbo_en` is high, utilisation is above the high threshold, and the number of active cores is at most `turbo_core_lim`. A core is active when its busy count in the window is nonzero.
- R10: While in turbo, a window that ends with `turbo_en` low, or with more active cores than `turbo_core_lim`, leaves turbo for index 0. This exit overrides a high-utilisation reading in the same window.
- R11: While in turbo and still granted, utilisation below the low threshold leaves turbo for index 0.
- R12: `ctl_pidx` and `ctl_turbo` show the committed selection from the cycle after the evaluation. The index never moves by more than one per change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_busy | input | NUM_CORES | Per-core busy flag, sampled every counting cycle |
| thr_hi | input | PCT_W | Raise threshold in percent |
| thr_lo | input | PCT_W | Lower threshold in percent |
| turbo_en | input | 1 | Software permission for turbo |
| turbo_core_lim | input | ACT_W | Largest active-core count that allows turbo |
| pair_tbl | input | NUM_PSTATES*(F_W+V_W) | Frequency/voltage pairs of the regular points |
| turbo_freq | input | F_W | Turbo frequency code |
| turbo_volt | input | V_W | Turbo voltage code |
| ctl_ack | input | 1 | One-cycle acknowledge of the current step |
| ctl_req | output | 1 | A step is presented and awaits acknowledge |
| ctl_freq | output | F_W | Frequency code being applied |
| ctl_volt | output | V_W | Voltage code being applied |
| ctl_pidx | output | IDX_W | Committed regular index |
| ctl_turbo | output | 1 | Committed turbo flag |

## Verification
Turbo revocation and a raise request can both arise from the same window. This happens when utilisation is above the high threshold while the enable is dropped or the active-core count exceeds the cap. The bench provokes this by switching `turbo_en` off, and separately by making four cores busy, exactly at the final acknowledge of the turbo entry. The next window therefore sees full load together with a lost grant. The scoreboard expects a lowering sequence to index 0: frequency first, then voltage. A raise or a held selection counts as a failure.

// File: rtl/pgov_pkg.sv
package pgov_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_EVAL  = 2'd1,
    ST_STEP1 = 2'd2,
    ST_STEP2 = 2'd3
  } pgov_state_e;

  // busy*100 strictly above pct*window
  function automatic logic util_exceeds(input int unsigned busy,
                                        input int unsigned pct,
                                        input int unsigned win);
    return (busy * 100) > (pct * win);
  endfunction

  // busy*100 strictly below pct*window
  function automatic logic util_short_of(input int unsigned busy,
                                         input int unsigned pct,
                                         input int unsigned win);
    return (busy * 100) < (pct * win);
  endfunction

  // performance rank: turbo above everything, smaller index above larger
  function automatic logic is_raise(input logic        t_old,
                                    input int unsigned i_old,
                                    input logic        t_new,
                                    input int unsigned i_new);
    return (t_new && !t_old) || (!t_new && !t_old && (i_new < i_old));
  endfunction

endpackage

// File: rtl/pgov_sampler.sv
module pgov_sampler #(
  parameter int NUM_CORES  = 4,
  parameter int WIN_CYCLES = 32,
  parameter int CNT_W      = 6,
  parameter int ACT_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 counting,
  input  logic                 clear,
  input  logic [NUM_CORES-1:0] core_busy,
  output logic                 win_end,
  output logic [CNT_W-1:0]     peak_busy,
  output logic [ACT_W-1:0]     active_cores
);
  localparam int TMR_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WIN_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] busy_q [NUM_CORES];

  always_ff @(posedge clk) begin
    if (!rst_n)        tmr_q <= '0;
    else if (clear)    tmr_q <= '0;
    else if (counting) tmr_q <= (tmr_q == TMR_LAST) ? '0 : tmr_q + 1'b1;
  end

  assign win_end = counting && (tmr_q == TMR_LAST);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n)                        busy_q[g] <= '0;
      else if (clear)                    busy_q[g] <= '0;
      else if (counting && core_busy[g]) busy_q[g] <= busy_q[g] + 1'b1;
    end
  end

  always_comb begin
    peak_busy    = '0;
    active_cores = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (busy_q[i] > peak_busy) peak_busy = busy_q[i];
      if (busy_q[i] != '0)       active_cores = active_cores + ACT_W'(1);
    end
  end

  // R2
  peak_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(peak_busy) <= WIN_CYCLES);

endmodule

// File: rtl/pgov_policy.sv
module pgov_policy #(
  parameter int NUM_PSTATES = 4,
  parameter int WIN_CYCLES  = 32,
  parameter int IDX_W       = 2,
  parameter int CNT_W       = 6,
  parameter int ACT_W       = 3,
  parameter int PCT_W       = 7
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             cur_turbo,
  input  logic [CNT_W-1:0] peak_busy,
  input  logic [ACT_W-1:0] active_cores,
  input  logic [PCT_W-1:0] thr_hi,
  input  logic [PCT_W-1:0] thr_lo,
  input  logic             turbo_en,
  input  logic [ACT_W-1:0] turbo_lim,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             nxt_turbo,
  output logic             step_up,
  output logic             step_any
);
  localparam logic [IDX_W-1:0] LOW_IDX = IDX_W'(NUM_PSTATES - 1);
  localparam int unsigned WIN_U = unsigned'(WIN_CYCLES);

  logic want_up;
  logic want_down;
  logic turbo_ok;

  always_comb begin
    want_up   = pgov_pkg::util_exceeds(32'(peak_busy), 32'(thr_hi), WIN_U);
    want_down = pgov_pkg::util_short_of(32'(peak_busy), 32'(thr_lo), WIN_U);
    turbo_ok  = turbo_en && (active_cores <= turbo_lim);

    nxt_idx   = cur_idx;
    nxt_turbo = cur_turbo;
    if (cur_turbo && !turbo_ok) begin
      nxt_turbo = 1'b0;
    end else if (want_up) begin
      if (cur_idx != '0)              nxt_idx   = cur_idx - 1'b1;
      else if (!cur_turbo && turbo_ok) nxt_turbo = 1'b1;
    end else if (want_down) begin
      if (cur_turbo)               nxt_turbo = 1'b0;
      else if (cur_idx != LOW_IDX) nxt_idx   = cur_idx + 1'b1;
    end

    step_any = (nxt_idx != cur_idx) || (nxt_turbo != cur_turbo);
    step_up  = pgov_pkg::is_raise(cur_turbo, 32'(cur_idx), nxt_turbo, 32'(nxt_idx));
  end

endmodule

// File: rtl/pgov_seq.sv
module pgov_seq #(
  parameter int NUM_PSTATES = 4,
  parameter int IDX_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   win_end,
  input  logic                   ack,
  input  logic [IDX_W-1:0]       nxt_idx,
  input  logic                   nxt_turbo,
  input  logic                   step_up,
  input  logic                   step_any,
  output pgov_pkg::pgov_state_e  state,
  output logic [IDX_W-1:0]       cur_idx,
  output logic                   cur_turbo,
  output logic [IDX_W-1:0]       f_idx,
  output logic                   f_turbo,
  output logic [IDX_W-1:0]       v_idx,
  output logic                   v_turbo,
  output logic                   req
);
  import pgov_pkg::*;

  localparam logic [IDX_W-1:0] LOW_IDX = IDX_W'(NUM_PSTATES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      cur_idx   <= LOW_IDX;
      cur_turbo <= 1'b0;
      f_idx     <= LOW_IDX;
      f_turbo   <= 1'b0;
      v_idx     <= LOW_IDX;
      v_turbo   <= 1'b0;
    end else begin
      case (state)
        ST_RUN: if (win_end) state <= ST_EVAL;
        ST_EVAL: begin
          if (step_any) begin
            cur_idx   <= nxt_idx;
            cur_turbo <= nxt_turbo;
            if (step_up) begin
              v_idx   <= nxt_idx;
              v_turbo <= nxt_turbo;
            end else begin
              f_idx   <= nxt_idx;
              f_turbo <= nxt_turbo;
            end
            state <= ST_STEP1;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_STEP1: if (ack) begin
          f_idx   <= cur_idx;
          f_turbo <= cur_turbo;
          v_idx   <= cur_idx;
          v_turbo <= cur_turbo;
          state   <= ST_STEP2;
        end
        default: if (ack) state <= ST_RUN;
      endcase
    end
  end

  assign req = (state == ST_STEP1) || (state == ST_STEP2);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // R7
  pair_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> ($stable(f_idx) && $stable(f_turbo) && $stable(v_idx) && $stable(v_turbo)));

  // R7
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STEP2 && ack) |=> !req);

endmodule

// File: rtl/pstate_governor.sv
module pstate_governor #(
  parameter int NUM_CORES   = 4,
  parameter int NUM_PSTATES = 4,
  parameter int WIN_CYCLES  = 32,
  parameter int F_W         = 8,
  parameter int V_W         = 8,
  parameter int PCT_W       = 7,
  localparam int IDX_W      = $clog2(NUM_PSTATES),
  localparam int ACT_W      = $clog2(NUM_CORES + 1),
  localparam int PAIR_W     = F_W + V_W,
  localparam int TBL_W      = NUM_PSTATES * PAIR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_busy,
  input  logic [PCT_W-1:0]     thr_hi,
  input  logic [PCT_W-1:0]     thr_lo,
  input  logic                 turbo_en,
  input  logic [ACT_W-1:0]     turbo_core_lim,
  input  logic [TBL_W-1:0]     pair_tbl,
  input  logic [F_W-1:0]       turbo_freq,
  input  logic [V_W-1:0]       turbo_volt,
  input  logic                 ctl_ack,
  output logic                 ctl_req,
  output logic [F_W-1:0]       ctl_freq,
  output logic [V_W-1:0]       ctl_volt,
  output logic [IDX_W-1:0]     ctl_pidx,
  output logic                 ctl_turbo
);
  import pgov_pkg::*;

  localparam int CNT_W = $clog2(WIN_CYCLES + 1);

  function automatic logic [F_W-1:0] tbl_freq(input logic [TBL_W-1:0] tbl,
                                               input logic [IDX_W-1:0] idx);
    return tbl[32'(idx) * PAIR_W + V_W +: F_W];
  endfunction

  function automatic logic [V_W-1:0] tbl_volt(input logic [TBL_W-1:0] tbl,
                                               input logic [IDX_W-1:0] idx);
    return tbl[32'(idx) * PAIR_W +: V_W];
  endfunction

  pgov_state_e      state;
  logic             win_end;
  logic [CNT_W-1:0] peak_busy;
  logic [ACT_W-1:0] active_cores;
  logic [IDX_W-1:0] cur_idx, nxt_idx, f_idx, v_idx;
  logic             cur_turbo, nxt_turbo, f_turbo, v_turbo;
  logic             step_up, step_any;
  logic             counting, clear;

  assign counting = (state == ST_RUN);
  assign clear    = (state == ST_EVAL);

  pgov_sampler #(
    .NUM_CORES (NUM_CORES),
    .WIN_CYCLES(WIN_CYCLES),
    .CNT_W     (CNT_W),
    .ACT_W     (ACT_W)
  ) u_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .counting    (counting),
    .clear       (clear),
    .core_busy   (core_busy),
    .win_end     (win_end),
    .peak_busy   (peak_busy),
    .active_cores(active_cores)
  );

  pgov_policy #(
    .NUM_PSTATES(NUM_PSTATES),
    .WIN_CYCLES (WIN_CYCLES),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W),
    .ACT_W      (ACT_W),
    .PCT_W      (PCT_W)
  ) u_policy (
    .cur_idx     (cur_idx),
    .cur_turbo   (cur_turbo),
    .peak_busy   (peak_busy),
    .active_cores(active_cores),
    .thr_hi      (thr_hi),
    .thr_lo      (thr_lo),
    .turbo_en    (turbo_en),
    .turbo_lim   (turbo_core_lim),
    .nxt_idx     (nxt_idx),
    .nxt_turbo   (nxt_turbo),
    .step_up     (step_up),
    .step_any    (step_any)
  );

  pgov_seq #(
    .NUM_PSTATES(NUM_PSTATES),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_end  (win_end),
    .ack      (ctl_ack),
    .nxt_idx  (nxt_idx),
    .nxt_turbo(nxt_turbo),
    .step_up  (step_up),
    .step_any (step_any),
    .state    (state),
    .cur_idx  (cur_idx),
    .cur_turbo(cur_turbo),
    .f_idx    (f_idx),
    .f_turbo  (f_turbo),
    .v_idx    (v_idx),
    .v_turbo  (v_turbo),
    .req      (ctl_req)
  );

  assign ctl_freq  = f_turbo ? turbo_freq : tbl_freq(pair_tbl, f_idx);
  assign ctl_volt  = v_turbo ? turbo_volt : tbl_volt(pair_tbl, v_idx);
  assign ctl_pidx  = cur_idx;
  assign ctl_turbo = cur_turbo;

  // R8
  no_eval_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> !ctl_req);

  // R12
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_pidx) |-> ((ctl_pidx == $past(ctl_pidx) + 1'b1) ||
                            (ctl_pidx + 1'b1 == $past(ctl_pidx))));

  // R9
  turbo_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_turbo) |-> (ctl_pidx == '0 && $past(turbo_en) &&
                          $past(active_cores) <= $past(turbo_core_lim)));

  // R5
  volt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_req) && ((ctl_turbo && !$past(ctl_turbo)) || (ctl_pidx < $past(ctl_pidx))))
      |-> $stable(ctl_freq));

  // R6
  freq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_req) && ((!ctl_turbo && $past(ctl_turbo)) || (ctl_pidx > $past(ctl_pidx))))
      |-> $stable(ctl_volt));

endmodule

// File: tb/pstate_governor_bench.sv
module pstate_governor_bench;

  localparam int NC  = 4;
  localparam int NP  = 4;
  localparam int WIN = 32;
  localparam int TF  = 240;
  localparam int TV  = 120;

  typedef struct {
    int    f;
    int    v;
    int    idx;
    bit    tb;
    bit    fin;
    bit    sw;
    logic [3:0] sw_busy;
    bit    sw_ten;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  core_busy = 4'b0001;
  logic [6:0]  thr_hi = 7'd75;
  logic [6:0]  thr_lo = 7'd25;
  logic        turbo_en = 1'b0;
  logic [2:0]  turbo_core_lim = 3'd2;
  logic [63:0] pair_tbl;
  logic        ctl_ack = 1'b0;
  logic        ctl_req;
  logic [7:0]  ctl_freq, ctl_volt;
  logic [1:0]  ctl_pidx;
  logic        ctl_turbo;

  int bf [NP] = '{200, 160, 120, 80};
  int bv [NP] = '{100, 90, 80, 70};

  exp_t sb[$];
  int   total = 0;
  int   bad = 0;
  int   ack_dly = 70;
  int   wcnt = 0;
  bit   have_snap = 0;
  bit   post_fin = 0;
  bit   duty_on = 0;
  bit   done = 0;
  int   snap_f, snap_v;

  always #2 clk = ~clk;

  pstate_governor u_pstate_governor (
    .clk(clk), .rst_n(rst_n), .core_busy(core_busy), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .turbo_en(turbo_en), .turbo_core_lim(turbo_core_lim), .pair_tbl(pair_tbl),
    .turbo_freq(8'(TF)), .turbo_volt(8'(TV)), .ctl_ack(ctl_ack), .ctl_req(ctl_req),
    .ctl_freq(ctl_freq), .ctl_volt(ctl_volt), .ctl_pidx(ctl_pidx), .ctl_turbo(ctl_turbo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rank(input bit t, input int i);
    return t ? NP : (NP - 1 - i);
  endfunction

  // driver: pushes the two expected steps of one change
  task automatic push_change(input bit ot, input int oi, input bit nt, input int ni,
                             input string tag, input bit sw = 0,
                             input logic [3:0] swb = 4'b0, input bit swt = 0);
    exp_t e1, e2;
    int fo, vo, fn, vn;
    bit up;
    fo = ot ? TF : bf[oi];
    vo = ot ? TV : bv[oi];
    fn = nt ? TF : bf[ni];
    vn = nt ? TV : bv[ni];
    up = rank(nt, ni) > rank(ot, oi);
    e1.f = up ? fo : fn;
    e1.v = up ? vn : vo;
    e1.idx = ni; e1.tb = nt; e1.fin = 0; e1.sw = 0; e1.sw_busy = '0; e1.sw_ten = 0;
    e1.tag = up ? "R5" : "R6";
    e2.f = fn; e2.v = vn; e2.idx = ni; e2.tb = nt; e2.fin = 1;
    e2.sw = sw; e2.sw_busy = swb; e2.sw_ten = swt; e2.tag = tag;
    sb.push_back(e1);
    sb.push_back(e2);
  endtask

  always @(negedge clk) begin
    if (duty_on) core_busy = ~core_busy;
  end

  // monitor / responder
  always @(negedge clk) begin
    if (!rst_n) begin
      ctl_ack = 1'b0;
      wcnt = 0;
      have_snap = 0;
    end else if (ctl_ack) begin
      ctl_ack = 1'b0;
      if (post_fin) chk(ctl_req == 1'b0, "R7 req after final ack", int'(ctl_req), 0);
      else          chk(ctl_req == 1'b1, "R7 req after first ack", int'(ctl_req), 1);
    end else if (ctl_req) begin
      if (!have_snap) begin
        snap_f = int'(ctl_freq);
        snap_v = int'(ctl_volt);
        have_snap = 1;
        wcnt = 0;
      end
      if (wcnt < ack_dly) begin
        wcnt++;
      end else begin
        chk(snap_f == int'(ctl_freq) && snap_v == int'(ctl_volt), "R7 pair held",
            int'(ctl_freq), snap_f);
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected request", int'(ctl_pidx), -1);
          post_fin = 0;
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(ctl_freq) == e.f, {e.tag, " freq"}, int'(ctl_freq), e.f);
          chk(int'(ctl_volt) == e.v, {e.tag, " volt"}, int'(ctl_volt), e.v);
          chk(int'(ctl_pidx) == e.idx, "R12 pidx", int'(ctl_pidx), e.idx);
          chk(ctl_turbo == e.tb, "R12 turbo", int'(ctl_turbo), int'(e.tb));
          post_fin = e.fin;
          if (e.sw) begin
            core_busy = e.sw_busy;
            turbo_en  = e.sw_ten;
          end
        end
        ctl_ack = 1'b1;
        have_snap = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    for (int i = 0; i < NP; i++) pair_tbl[i*16 +: 16] = {8'(bf[i]), 8'(bv[i])};

    // A: raises with turbo disabled (R2)
    push_change(0, 3, 0, 2, "R2");
    push_change(0, 2, 0, 1, "R2");
    push_change(0, 1, 0, 0, "R2", 1, 4'b0000, 0);
    // B: lowers to floor (R3)
    push_change(0, 0, 0, 1, "R3");
    push_change(0, 1, 0, 2, "R3");
    push_change(0, 2, 0, 3, "R3", 1, 4'b0001, 1);
    // C: raises then turbo grant (R2, R9)
    push_change(0, 3, 0, 2, "R2");
    push_change(0, 2, 0, 1, "R2");
    push_change(0, 1, 0, 0, "R2");
    push_change(0, 0, 1, 0, "R9", 1, 4'b1111, 1);
    // D: too many active cores under full load (R10)
    push_change(1, 0, 0, 0, "R10 core cap", 1, 4'b0011, 1);
    // E: two cores fit the cap (R9)
    push_change(0, 0, 1, 0, "R9 at cap", 1, 4'b0011, 0);
    // F: enable dropped while load is high (R10)
    push_change(1, 0, 0, 0, "R10 enable off", 1, 4'b0001, 1);
    // H: regrant, then idle
    push_change(0, 0, 1, 0, "R9", 1, 4'b0000, 1);
    // G: low load leaves turbo, then down to floor (R11, R3)
    push_change(1, 0, 0, 0, "R11");
    push_change(0, 0, 0, 1, "R3");
    push_change(0, 1, 0, 2, "R3");
    push_change(0, 2, 0, 3, "R3");
    n0 = sb.size();

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctl_pidx == 2'd3, "R1 pidx", int'(ctl_pidx), 3);
    chk(ctl_turbo == 1'b0, "R1 turbo", int'(ctl_turbo), 0);
    chk(ctl_freq == 8'd80 && ctl_volt == 8'd70, "R1 R4 pair", int'(ctl_freq), 80);
    chk(ctl_req == 1'b0, "R1 req", int'(ctl_req), 0);
    rst_n = 1'b1;

    // R8: first step held 70 cycles, longer than a window
    wait (sb.size() == n0 - 1);
    ack_dly = 2;
    wait (sb.size() == 0 && ctl_ack == 1'b0);
    repeat (200) @(negedge clk);
    chk(ctl_pidx == 2'd3 && ctl_req == 1'b0, "R3 floor hold", int'(ctl_pidx), 3);
    chk(ctl_freq == 8'd80 && ctl_volt == 8'd70, "R4 floor pair", int'(ctl_volt), 70);

    // boundaries at 50% load on all cores
    @(negedge clk);
    rst_n = 1'b0;
    thr_hi = 7'd50;
    thr_lo = 7'd25;
    turbo_en = 1'b0;
    core_busy = 4'b0101;
    duty_on = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (12 * WIN) @(negedge clk);
    chk(ctl_pidx == 2'd3 && ctl_req == 1'b0, "R2 equal to high holds", int'(ctl_pidx), 3);

    push_change(0, 3, 0, 2, "R2 just above");
    push_change(0, 2, 0, 1, "R2 just above");
    push_change(0, 1, 0, 0, "R2 just above");
    thr_hi = 7'd49;
    wait (sb.size() == 0 && ctl_ack == 1'b0);
    repeat (100) @(negedge clk);
    thr_hi = 7'd100;
    thr_lo = 7'd50;
    repeat (12 * WIN) @(negedge clk);
    chk(ctl_pidx == 2'd0 && ctl_req == 1'b0, "R3 equal to low holds", int'(ctl_pidx), 0);

    push_change(0, 0, 0, 1, "R3 just below");
    push_change(0, 1, 0, 2, "R3 just below");
    push_change(0, 2, 0, 3, "R3 just below");
    thr_lo = 7'd51;
    wait (sb.size() == 0 && ctl_ack == 1'b0);
    repeat (100) @(negedge clk);
    chk(ctl_pidx == 2'd3 && ctl_req == 1'b0, "R3 end state", int'(ctl_pidx), 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule